// File: doc/BRIEF.md
# External Interrupt Sense and Wake Unit

This unit watches one external interrupt pin and turns its activity into an interrupt request for a processor core. The pin first passes through a two-stage synchroniser and one more sample register, so edge detection always compares two registered samples. A two-bit sense selection picks what counts as an event: low level, any toggle, falling edge or rising edge. In the edge and toggle selections a sticky flag records the event until the core acknowledges it or software clears it. In the low-level selection the flag follows the level. The core qualifies that level with a pulse it gives when an instruction completes.

While the core sleeps, the system clock keeps running but the pin level is judged only on slow sample ticks, one system-clock cycle wide each. Two ticks in a row that both see the low level start a start-up countdown, and its length comes from two selection bits. When the countdown ends the core is woken. The interrupt flag is raised only if the low level is still present at that moment. If the low has gone, the core wakes but no interrupt is raised. The request reaches the core only when both the global enable and this source's mask are set.

Top module: `extint_unit`

## Requirements
- R1: The pin passes through two synchroniser flops before it is compared with the previous registered sample. A pin change made between clock edges shows on `flag_o` after the third rising clock edge that follows it, and not after the second.
- R2: The sense selection `sense_i` is encoded as 0 = low level, 1 = any toggle, 2 = falling edge (synchronised pin goes 1 to 0), 3 = rising edge (0 to 1). In an edge selection, a transition of the other direction leaves the flag unchanged.
- R3: In the toggle and edge selections the flag stays set until `ack_i` or `clr_i` is high on a clock edge. A new event on the same edge takes priority over the clear. The flag is held at 0 while the low-level selection is active.
- R4: `irq_o` is high exactly when `flag_o`, `gie_i` and `mask_i` are all high.
- R5: In the low-level selection, `flag_o` takes the value "synchronised pin is low" on each clock edge with `instr_done_i` high. It drops on the first edge at which the synchronised pin is high. Without a qualifying pulse it does not set.
- R6: With `sleep_i` high and the low-level selection active, a `wd_tick_i` tick that sees the synchronised pin low arms the unit. The next tick starts the start-up countdown if it also sees low, and disarms the unit if it sees high.
- R7: The start-up length is 4 << (2 × `su_sel_i`) clock cycles (4, 16, 64 or 256). `wake_o` rises on exactly that many clock edges after the edge that took the second low tick.
- R8: On the edge where `wake_o` rises, the flag is set if the synchronised pin is still low. If the pin has gone high, the core is woken with the flag clear and no request.
- R9: `wake_o` stays high for as long as `sleep_i` stays high. It falls on the first edge with `sleep_i` low, and a low `sleep_i` also abandons any armed state or countdown in progress.
- R10: After a synchronous reset, `irq_o`, `wake_o` and `flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| sense_i | input | 2 | Sense selection (0 low, 1 toggle, 2 fall, 3 rise) |
| gie_i | input | 1 | Global interrupt enable |
| mask_i | input | 1 | Mask bit of this source |
| sleep_i | input | 1 | Core is asleep |
| wd_tick_i | input | 1 | Slow sample tick, one clock wide |
| instr_done_i | input | 1 | Instruction completion pulse from the core |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| su_sel_i | input | 2 | Start-up length selection |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake the core |
| flag_o | output | 1 | Interrupt flag |

## Verification
Single directed transitions check the three-edge latency and tell the rising, falling and toggle selections apart, because each selection must ignore the transitions that the others accept. A low level with and without a completion pulse separates a qualified level from a raw one. Three sleep sequences are run: a low held through start-up, a low that is seen twice but then vanishes, and a single low tick followed by high. They separate a wake with an interrupt, a wake without one, and no wake at all. Long random runs of pin toggles, acknowledges, clears and enable changes in each selection are compared cycle by cycle against a bench model. These runs catch clears that happen at the same moment as a new event.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW    = 2'd0,
        SENSE_TOGGLE = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_RISE   = 2'd3
    } sense_e;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ARM   = 2'd1,
        W_START = 2'd2,
        W_WAKE  = 2'd3
    } wake_st_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_samp_t;

    function automatic int unsigned su_len(input int unsigned base, input int unsigned sel);
        return base << (2 * sel);
    endfunction

    function automatic logic sense_event(input sense_e mode, input pin_samp_t s);
        logic ev;
        case (mode)
            SENSE_TOGGLE: ev = s.cur ^ s.prev;
            SENSE_FALL:   ev = s.prev & ~s.cur;
            SENSE_RISE:   ev = ~s.prev & s.cur;
            default:      ev = 1'b0;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync
    import extint_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_samp_t samp_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], pin_i};
        end
    end

    always_comb begin
        samp_o.cur  = chain_q[DEPTH-2];
        samp_o.prev = chain_q[DEPTH-1];
    end

    p_prev_follows_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (samp_o.prev == $past(samp_o.cur)));

endmodule

// File: rtl/extint_edge.sv
module extint_edge
    import extint_pkg::*;
(
    input  sense_e    mode_i,
    input  pin_samp_t samp_i,
    output logic      event_o
);
    always_comb begin
        event_o = sense_event(mode_i, samp_i);
    end
endmodule

// File: rtl/extint_wake.sv
module extint_wake
    import extint_pkg::*;
#(
    parameter int unsigned SU_BASE  = 4,
    parameter int unsigned SU_SEL_W = 2,
    localparam int unsigned MAX_LEN = SU_BASE << (2 * ((1 << SU_SEL_W) - 1)),
    localparam int unsigned CNT_W   = $clog2(MAX_LEN) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_i,
    input  logic                lvl_mode_i,
    input  logic                tick_i,
    input  logic                low_i,
    input  logic [SU_SEL_W-1:0] su_sel_i,
    output logic                wake_o,
    output logic                fire_o
);
    wake_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(su_len(SU_BASE, int'(su_sel_i)) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                W_IDLE: begin
                    if (sleep_i && lvl_mode_i && tick_i && low_i) st_q <= W_ARM;
                end
                W_ARM: begin
                    if (!sleep_i || !lvl_mode_i) begin
                        st_q <= W_IDLE;
                    end else if (tick_i) begin
                        if (low_i) begin
                            st_q  <= W_START;
                            cnt_q <= load_val;
                        end else begin
                            st_q <= W_IDLE;
                        end
                    end
                end
                W_START: begin
                    if (!sleep_i) st_q <= W_IDLE;
                    else if (cnt_q == '0) st_q <= W_WAKE;
                    else cnt_q <= cnt_q - 1'b1;
                end
                default: begin
                    if (!sleep_i) st_q <= W_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        wake_o = (st_q == W_WAKE);
        fire_o = (st_q == W_START) && sleep_i && (cnt_q == '0);
    end

    p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == W_START && sleep_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_wake_from_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_o) |-> $past(st_q == W_START));

    p_wake_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_o && sleep_i) |=> wake_o);

    p_no_sleep_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !sleep_i |=> (st_q == W_IDLE));

endmodule

// File: rtl/extint_unit.sv
module extint_unit
    import extint_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SU_BASE     = 4,
    parameter int unsigned SU_SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_i,
    input  logic [1:0]          sense_i,
    input  logic                gie_i,
    input  logic                mask_i,
    input  logic                sleep_i,
    input  logic                wd_tick_i,
    input  logic                instr_done_i,
    input  logic                ack_i,
    input  logic                clr_i,
    input  logic [SU_SEL_W-1:0] su_sel_i,
    output logic                irq_o,
    output logic                wake_o,
    output logic                flag_o
);
    sense_e    mode;
    pin_samp_t samp;
    logic      ev;
    logic      low;
    logic      lvl_mode;
    logic      fire;
    logic      flag_q;
    logic      lvl_q;

    always_comb begin
        mode     = sense_e'(sense_i);
        low      = ~samp.cur;
        lvl_mode = (mode == SENSE_LOW);
    end

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .samp_o (samp)
    );

    extint_edge u_edge (
        .mode_i  (mode),
        .samp_i  (samp),
        .event_o (ev)
    );

    extint_wake #(.SU_BASE(SU_BASE), .SU_SEL_W(SU_SEL_W)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .sleep_i    (sleep_i),
        .lvl_mode_i (lvl_mode),
        .tick_i     (wd_tick_i),
        .low_i      (low),
        .su_sel_i   (su_sel_i),
        .wake_o     (wake_o),
        .fire_o     (fire)
    );

    // sticky event flag for the edge and toggle selections
    always_ff @(posedge clk) begin
        if (rst || lvl_mode) flag_q <= 1'b0;
        else if (ev) flag_q <= 1'b1;
        else if (ack_i || clr_i) flag_q <= 1'b0;
    end

    // qualified level for the low-level selection
    always_ff @(posedge clk) begin
        if (rst || !lvl_mode) lvl_q <= 1'b0;
        else if (instr_done_i || fire) lvl_q <= low;
        else lvl_q <= lvl_q & low;
    end

    always_comb begin
        flag_o = lvl_mode ? lvl_q : flag_q;
        irq_o  = flag_o & gie_i & mask_i;
    end

    p_event_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode && ev) |=> flag_q);

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode && flag_q && !ack_i && !clr_i) |=> flag_q);

    p_level_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (lvl_mode && !low) |=> !lvl_q);

    p_fire_keeps_low_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && lvl_mode && low) |=> lvl_q);

endmodule

// File: tb/sim_extint_unit.sv
`timescale 1ns/1ps
module sim_extint_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b1;
    logic [1:0] sense = 2'd0;
    logic       gie = 1'b0;
    logic       mask = 1'b0;
    logic       sleep = 1'b0;
    logic       tick = 1'b0;
    logic       done = 1'b0;
    logic       ack = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       irq, wake, flag;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    extint_unit u0 (
        .clk(clk), .rst(rst), .pin_i(pin), .sense_i(sense), .gie_i(gie),
        .mask_i(mask), .sleep_i(sleep), .wd_tick_i(tick), .instr_done_i(done),
        .ack_i(ack), .clr_i(clr), .su_sel_i(sel),
        .irq_o(irq), .wake_o(wake), .flag_o(flag)
    );

    // bench model of the awake behaviour, built from the requirements
    logic m_s1, m_s2, m_prev, m_flag, m_lvl;

    function automatic logic exp_event(input logic [1:0] md, input logic cur, input logic prv);
        case (md)
            2'd1:    return cur ^ prv;
            2'd2:    return prv & ~cur;
            2'd3:    return ~prv & cur;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_len(input logic [1:0] s);
        return 4 << (2 * s);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1; m_flag <= 1'b0; m_lvl <= 1'b0;
        end else begin
            if (sense == 2'd0) m_flag <= 1'b0;
            else if (exp_event(sense, m_s2, m_prev)) m_flag <= 1'b1;
            else if (ack || clr) m_flag <= 1'b0;
            if (sense != 2'd0) m_lvl <= 1'b0;
            else if (done) m_lvl <= ~m_s2;
            else m_lvl <= m_lvl & ~m_s2;
            m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pin;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        cyc(2); rst = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c));
        cyc(3);
        // R10 reset state
        chk("R10 irq", irq, 1'b0); chk("R10 wake", wake, 1'b0); chk("R10 flag", flag, 1'b0);
        rst = 1'b0;
        gie = 1'b1; mask = 1'b1;

        // R2 rising selection ignores a falling transition, R1 latency on a rising one
        sense = 2'd3;
        cyc(1); pin = 1'b0;
        cyc(4); chk("R2 rise ignores fall", flag, 1'b0);
        pin = 1'b1;
        cyc(2); chk("R1 not yet after two edges", flag, 1'b0);
        cyc(1); chk("R1 set after third edge", flag, 1'b1);
        chk("R4 irq with both enables", irq, 1'b1);

        // R4 enable gating
        gie = 1'b0; #1 chk("R4 gie low", irq, 1'b0);
        gie = 1'b1; mask = 1'b0; #1 chk("R4 mask low", irq, 1'b0);
        mask = 1'b1;

        // R3 sticky and acknowledge
        cyc(5); chk("R3 sticky", flag, 1'b1);
        ack = 1'b1; cyc(1); ack = 1'b0;
        chk("R3 ack clears", flag, 1'b0);

        // R2 falling selection, then clear strobe
        sense = 2'd2;
        pin = 1'b0; cyc(3); chk("R2 fall sets", flag, 1'b1);
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk("R3 clr clears", flag, 1'b0);
        pin = 1'b1; cyc(4); chk("R2 fall ignores rise", flag, 1'b0);

        // R5 level selection needs a completion pulse
        sense = 2'd0;
        pin = 1'b0; cyc(4); chk("R5 no pulse no flag", flag, 1'b0);
        done = 1'b1; cyc(1); done = 1'b0;
        chk("R5 pulse sets", flag, 1'b1);
        pin = 1'b1; cyc(2); chk("R5 still set", flag, 1'b1);
        cyc(1); chk("R5 drops with level", flag, 1'b0);

        // R6 R7 R8 wake with level held
        sel = 2'd1;
        pin = 1'b0; cyc(3);
        sleep = 1'b1;
        pulse_tick(); pulse_tick();
        cyc(exp_len(sel) - 1); chk("R7 not yet awake", wake, 1'b0);
        cyc(1); chk("R7 wake on time", wake, 1'b1);
        chk("R8 flag when held", flag, 1'b1); chk("R8 irq when held", irq, 1'b1);
        cyc(6); chk("R9 wake held", wake, 1'b1);
        sleep = 1'b0; cyc(1); chk("R9 wake falls", wake, 1'b0);
        pin = 1'b1; cyc(4);

        // R8 level vanishes during start-up
        sel = 2'd0;
        pin = 1'b0; cyc(3);
        sleep = 1'b1;
        pulse_tick(); pulse_tick();
        pin = 1'b1;
        cyc(exp_len(sel)); chk("R8 wake without level", wake, 1'b1);
        chk("R8 no flag", flag, 1'b0); chk("R8 no irq", irq, 1'b0);
        sleep = 1'b0; cyc(2);

        // R6 one low tick then high: no wake
        pin = 1'b0; cyc(3);
        sleep = 1'b1;
        pulse_tick();
        pin = 1'b1; cyc(3);
        pulse_tick();
        cyc(300); chk("R6 broken pair no wake", wake, 1'b0);
        // R9 sleep drop abandons countdown
        pin = 1'b0; cyc(3);
        sel = 2'd3;
        pulse_tick(); pulse_tick();
        cyc(10); sleep = 1'b0;
        cyc(300); chk("R9 abandoned countdown", wake, 1'b0);
        pin = 1'b1; sel = 2'd0;

        // random runs per selection against the bench model (R1 R2 R3 R4 R5)
        do_reset();
        for (int md = 0; md < 4; md++) begin
            sense = 2'(md);
            for (int i = 0; i < 1500; i++) begin
                @(negedge clk);
                chk("R3 flag vs model", flag, (sense == 2'd0) ? m_lvl : m_flag);
                chk("R4 irq vs model", irq, ((sense == 2'd0) ? m_lvl : m_flag) & gie & mask);
                chk("R9 no wake awake", wake, 1'b0);
                if ($urandom % 3 == 0) pin = ~pin;
                ack  = ($urandom % 8 == 0);
                clr  = ($urandom % 16 == 0);
                done = ($urandom % 3 == 0);
                gie  = ($urandom % 4 != 0);
                mask = ($urandom % 4 != 0);
            end
        end
        ack = 1'b0; clr = 1'b0; done = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule